// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing front end of a small serial memory. It runs on a fast system clock and oversamples the two-wire bus lines. It finds START and STOP conditions and decodes the device-select byte. It then takes a byte address, accepts write bytes into a separate page buffer or streams read bytes back, and pulls the data line low through an open-drain enable.

A companion storage block holds the array and the page buffer. The controller sends it single-byte writes, each with an address and data. It asks that block to commit a page when a write transfer ends with a STOP. While the storage block raises its busy flag, the controller stops answering its address. A master can therefore poll for the end of an internal write.

A parameter selects between two variants. The narrow variant uses 8-bit addresses and compares all three select bits. The wide variant uses 9-bit addresses and takes the lowest select bit as address bit 8. A write-protect input guards the upper half of the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line enable is off, and no byte write or commit is signalled.
- R2: Bus traffic is ignored until a START is seen, where START is SDA falling while SCL is high. Bytes clocked without a START get no acknowledge.
- R3: The first byte after START is acknowledged only if its top four bits are 1010 and its select bits (bits 3..1 narrow, bits 3..2 wide) equal the strap pins. Bit 0 chooses read (1) or write (0). The acknowledge is SDA held low during the 9th SCL clock.
- R4: In the wide variant, bit 1 of the select byte is not compared with pin 0. Instead it becomes address bit 8 for the transfer.
- R5: In a write transfer, the byte after the select byte loads the low address bits. Every data byte after that is acknowledged and issued as a one-cycle write with its address. A STOP that follows at least one accepted data byte produces a single commit pulse.
- R6: After each accepted write byte, only the low four address bits advance, wrapping within a 16-byte page. The upper bits stay unchanged.
- R7: In a read transfer, bytes are sent MSB first. Bits change after SCL falls, and a 1 is sent by releasing the line. Each byte is read from the current pointer, which then advances across the full address range. The controller keeps sending while the master acknowledges. After a NoACK it releases the line and waits for the next START.
- R8: While the storage busy flag is high, the select byte is not acknowledged.
- R9: The write-protect input is sampled on the SCL falling edge that ends the byte-address acknowledge. If it was high and the target lies in the upper half, the data byte is not acknowledged, no write is issued and no commit follows. Changing the input after that edge has no effect on the transfer.
- R10: A write transfer that stops right after the byte address only loads the pointer and issues no commit. A following read starts at that address.
- R11: A START in the middle of a transfer returns the controller to the select-byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| sel_pins | input | 3 | Strapped select pins {A2,A1,A0} |
| wp | input | 1 | Write protect for the upper half |
| mem_busy | input | 1 | Storage block internal write in progress |
| rd_data | input | 8 | Byte at rd_addr from storage |
| sda_oe | output | 1 | Pull data line low when 1 |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 8+WIDE_ADDR | Byte write address |
| wr_data | output | 8 | Byte write data |
| commit | output | 1 | One-cycle request to program the buffered page |
| rd_addr | output | 8+WIDE_ADDR | Current read pointer |

## Verification
Select bytes are sent with a wrong type nibble, wrong select bits, a clean match and a match during busy, so that address decoding can be told apart from busy polling. Writes go to single bytes, to an 18-byte burst that must fold back inside its page, and to both halves with write protect high or raised late, which separates the page wrap and the protect window from ordinary acceptance. Reads follow a dummy write ended by STOP and one ended by a repeated START. This shows that the pointer is loaded without a commit and that the read then continues across a page edge.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int WIDE_ADDR = 1,
  parameter int PAGE_BITS = 4,
  localparam int AW = 8 + WIDE_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [2:0]    sel_pins,
  input  logic          wp,
  input  logic          mem_busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic [AW-1:0] rd_addr
);

  typedef enum logic [2:0] {IDLE, DEV, WADR, WDAT, RD, WAIT} st_t;

  st_t          st;
  logic [2:0]   scl_sy, sda_sy;
  logic [3:0]   bitcnt;
  logic         in_ack, rd_go, got_data, wp_lat;
  logic [7:0]   sr, tx;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  wire scl_s = scl_sy[1], scl_p = scl_sy[2];
  wire sda_s = sda_sy[1], sda_p = sda_sy[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  wire sel_ok   = (WIDE_ADDR != 0) ? (sr[3:2] == sel_pins[2:1]) : (sr[3:1] == sel_pins);
  wire dev_hit  = (sr[7:4] == 4'b1010) && sel_ok && !mem_busy;
  wire wp_block = wp_lat && ptr[AW-1];

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; bitcnt <= '0; in_ack <= 1'b0; rd_go <= 1'b0;
      got_data <= 1'b0; wp_lat <= 1'b0; sr <= '0; tx <= '0; ptr <= '0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; commit <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      commit <= 1'b0;
      if (start_det) begin
        st <= DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; got_data <= 1'b0;
      end else if (stop_det) begin
        if (st == WDAT && got_data) commit <= 1'b1;
        st <= IDLE; sda_oe <= 1'b0; in_ack <= 1'b0;
      end else if (st != IDLE && st != WAIT) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            in_ack <= 1'b1;
            if (st == RD) rd_go <= ~sda_s;
          end else begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            if (st == WDAT && !got_data) wp_lat <= wp;
            if (st == RD) begin
              if (rd_go) begin
                tx     <= rd_data;
                ptr    <= ptr + 1'b1;
                sda_oe <= ~rd_data[7];
              end else st <= WAIT;
            end
          end else if (bitcnt == 4'd8) begin
            case (st)
              DEV:
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  rd_go  <= 1'b1;
                  st     <= sr[0] ? RD : WADR;
                  if (WIDE_ADDR != 0) ptr[AW-1] <= sr[1];
                end else st <= WAIT;
              WADR: begin
                ptr[7:0] <= sr;
                sda_oe   <= 1'b1;
                st       <= WDAT;
              end
              WDAT:
                if (wp_block) st <= WAIT;
                else begin
                  sda_oe   <= 1'b1;
                  wr_en    <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= sr;
                  got_data <= 1'b1;
                  ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
                end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == RD && bitcnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE || st == WAIT) |-> !sda_oe);

  // R5
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det));

  // R5
  wr_commit_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && commit));

  // R9
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(wp_lat && wr_addr[AW-1]));

  // R7
  oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int AW = 9;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b011;
  logic sda_oe, wr_en, commit, busy;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.WIDE_ADDR(1), .PAGE_BITS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sel_pins(pins),
    .wp(wp), .mem_busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit), .rd_addr(rd_addr));

  function automatic logic [7:0] f(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  logic [7:0] mem [0:511];
  logic [16:0] pend [$];
  logic [16:0] exp_q [$];
  int busy_cnt = 0, n_commit = 0, n_chk = 0, n_err = 0;
  assign busy = busy_cnt != 0;
  assign rd_data = mem[rd_addr];

  initial for (int i = 0; i < 512; i++) mem[i] = f(i);

  always @(negedge clk) begin
    if (busy_cnt != 0) busy_cnt--;
    if (wr_en) pend.push_back({wr_addr, wr_data});
    if (commit) begin
      n_commit++;
      busy_cnt = BUSY_CYC;
      while (pend.size() != 0) begin
        logic [16:0] e;
        e = pend.pop_front();
        mem[e[16:8]] = e[7:0];
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) if (rst_n && wr_en) begin
    if (exp_q.size() == 0) chk("R5/R9 unexpected write", {15'd0, wr_addr, wr_data}, 32'h1ffff);
    else begin
      logic [16:0] e;
      e = exp_q.pop_front();
      chk("R5/R6 write addr/data", {15'd0, wr_addr, wr_data}, {15'd0, e});
    end
  end

  task automatic expect_wr(int a, logic [7:0] d);
    exp_q.push_back({9'(a), d});
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; w(Q); scl_m = 1'b1; w(Q); r = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~mack, r);
  endtask

  function automatic logic [7:0] dev(logic a8, logic rw);
    return {4'b1010, 2'b01, a8, rw};
  endfunction

  task automatic run;
    logic ack;
    logic [7:0] d;
    int c0;
    rst_n = 1'b0; w(5);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 commit", commit, 0);
    rst_n = 1'b1; w(10);

    // R2: a matching byte clocked without START
    wr_byte(dev(0, 0), ack);
    chk("R2 no ack without START", ack, 0);
    i_stop(); w(20);

    // R3: wrong type nibble, wrong select bits
    i_start(); wr_byte(8'hB2, ack); chk("R3 wrong type nacked", ack, 0); i_stop();
    i_start(); wr_byte({4'b1010, 2'b11, 2'b00}, ack); chk("R3 wrong select nacked", ack, 0); i_stop();

    // R5 byte write (pin 0 is high while bit 1 is 0: R4 not compared)
    i_start(); wr_byte(dev(0, 0), ack); chk("R3/R4 matching select acked", ack, 1);
    wr_byte(8'h20, ack); chk("R5 address byte acked", ack, 1);
    expect_wr(12'h020, 8'h3C);
    wr_byte(8'h3C, ack); chk("R5 data byte acked", ack, 1);
    c0 = n_commit; i_stop(); w(4);
    chk("R5 one commit on STOP", n_commit - c0, 1);
    // R8 polling while busy
    i_start(); wr_byte(dev(0, 0), ack); chk("R8 nack while busy", ack, 0); i_stop();
    w(BUSY_CYC + 50);
    i_start(); wr_byte(dev(0, 0), ack); chk("R8 ack once idle", ack, 1); i_stop(); w(20);

    // R4 upper half through select bit
    i_start(); wr_byte(dev(1, 0), ack); wr_byte(8'h05, ack);
    expect_wr(12'h105, 8'h77);
    wr_byte(8'h77, ack); chk("R4 upper-half write acked", ack, 1);
    i_stop(); w(BUSY_CYC + 50);

    // R6 18-byte burst wraps inside the page
    i_start(); wr_byte(dev(0, 0), ack); wr_byte(8'h4E, ack);
    for (int k = 0; k < 18; k++) begin
      expect_wr(12'h040 | ((14 + k) & 15), 8'(8'h80 + k));
      wr_byte(8'(8'h80 + k), ack);
      if (k == 17) chk("R6 wrapped byte acked", ack, 1);
    end
    i_stop(); w(BUSY_CYC + 50);

    // R10 dummy write then read
    c0 = n_commit;
    i_start(); wr_byte(dev(0, 0), ack); wr_byte(8'h10, ack); i_stop(); w(10);
    chk("R10 no commit for address-only write", n_commit - c0, 0);
    i_start(); wr_byte(dev(0, 1), ack); chk("R10 read select acked", ack, 1);
    rd_byte(1'b0, d); chk("R10 read at dummy address", d, f(16));
    i_stop(); w(20);

    // R11 repeated START after address, then R7 sequential read across page
    i_start(); wr_byte(dev(0, 0), ack); wr_byte(8'h4E, ack);
    i_start(); wr_byte(dev(0, 1), ack); chk("R11 select after repeated START acked", ack, 1);
    rd_byte(1'b1, d); chk("R7/R6 read 0x04E", d, 8'h90);
    rd_byte(1'b1, d); chk("R7/R6 read 0x04F", d, 8'h91);
    rd_byte(1'b1, d); chk("R7 read 0x050", d, f(16'h50));
    rd_byte(1'b0, d); chk("R7 read 0x051", d, f(16'h51));
    chk("R7 line released after NoACK", sda_oe, 0);
    i_stop(); w(20);

    // R9 protected upper half
    wp = 1'b1; c0 = n_commit;
    i_start(); wr_byte(dev(1, 0), ack); wr_byte(8'h30, ack);
    wr_byte(8'h11, ack); chk("R9 protected byte nacked", ack, 0);
    i_stop(); w(10);
    chk("R9 no commit after reject", n_commit - c0, 0);
    // R9 lower half unaffected
    i_start(); wr_byte(dev(0, 0), ack); wr_byte(8'h30, ack);
    expect_wr(12'h030, 8'h22);
    wr_byte(8'h22, ack); chk("R9 lower half acked with wp high", ack, 1);
    i_stop(); w(BUSY_CYC + 50);
    // R9 wp raised after the sampling edge
    wp = 1'b0;
    i_start(); wr_byte(dev(1, 0), ack); wr_byte(8'h31, ack);
    expect_wr(12'h131, 8'h33);
    fork
      wr_byte(8'h33, ack);
      begin w(4 * Q * 3); wp = 1'b1; end
    join
    chk("R9 late wp ignored", ack, 1);
    c0 = n_commit; i_stop(); w(10); wp = 1'b0;
    chk("R9 late wp write committed", n_commit - c0, 1);
    w(20);
    chk("R5 all expected writes seen", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule